// File: doc/BRIEF.md
# Sleep-State Pin Hold Controller

This block sits between a group of peripheral pads and the peripherals that own them. In normal operation each pad's output value and output enable come straight from its peripheral. When the power manager signals sleep entry, the pads switch to a programmed sleep state. In that state a pad is either driven low or turned into an input, as selected by one bit per pad in a direction register. The pads stay in that state after wake-up until software writes the release flag.

The direction register covers 22 pads. Bits 7..0 are LCD data. Bits 8..11 are the LCD pixel clock, line clock, frame clock and AC bias. Bits 12..19 are the transmit/receive pairs of serial ports 1 to 4. Bits 20..21 are the serial clock and frame. Only the hardware reset initialises this register, and it keeps its contents through soft resets and sleep entry. The block also keeps the two polarity bits of serial port 2. Both return to 1 (non-inverted data) on any peripheral reset, which here means a soft reset or sleep entry.

A hold state machine has two states, ST_RELEASED and ST_HELD. Its transitions are:
- SLEEP_ENTRY goes from ST_RELEASED to ST_HELD when the sleep strobe is sampled.
- SLEEP_AGAIN keeps the machine in ST_HELD when the sleep strobe is sampled there.
- RELEASE goes from ST_HELD to ST_RELEASED on a write of 1 to the release flag with no sleep strobe in the same cycle.
- STAY keeps the current state in every other case.

The hardware reset puts the machine in ST_RELEASED.

Top module: `pin_sleep_hold`

## Requirements
- R1: After hardware reset, the direction register reads 0x003FFFFF at address 0. The control word at address 1 reads 0x7, with bit 0 = release flag, bit 1 = serial-2 transmit polarity and bit 2 = serial-2 receive polarity. Both polarity outputs are 1, and the pins follow the peripherals.
- R2: A write to address 0 updates all 22 direction bits at once. Bits 31..22 ignore writes and read as zero.
- R3: A read with bus_re high returns its data on bus_rdata one clock after the request. bus_rdata is zero in cycles with no read.
- R4: While the release flag is 1, pin_out equals periph_out and pin_oe equals periph_oe for every pin.
- R5: While the release flag is 0, every pin_out is 0 and pin_oe[i] is the inverse of direction bit i. A direction bit of 0 means the pin is driven low; a direction bit of 1 means it is an input.
- R6: A sampled sleep strobe clears the release flag. The strobe wins over a release write in the same cycle.
- R7: Writing 1 to control bit 0 sets the release flag. Writing 0 there leaves it unchanged, and the flag reads back its current state.
- R8: Soft reset and sleep entry leave the direction register unchanged.
- R9: The serial-2 polarity bits can be written through control bits 1 and 2. They return to 1 on soft reset or sleep entry, and that reset wins over a write in the same cycle.
- R10: A direction write while the pins are held changes the pins from the clock edge that stores the write, and not before.
- R11: Writes to unmapped addresses are ignored, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware/power-on reset, active low |
| soft_rst | input | 1 | Synchronous software reset pulse, active high |
| sleep_req | input | 1 | Sleep-entry strobe, sampled on the clock |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read request |
| bus_addr | input | 2 | Word address: 0 direction, 1 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_re |
| periph_out | input | 22 | Output values from the owning peripherals |
| periph_oe | input | 22 | Output enables from the owning peripherals |
| pin_out | output | 22 | Output value to the pads |
| pin_oe | output | 22 | Output enable to the pads |
| ser2_tx_pol | output | 1 | Serial port 2 transmit polarity, 1 = non-inverted |
| ser2_rx_pol | output | 1 | Serial port 2 receive polarity, 1 = non-inverted |

## Verification
The assertions check several rules on every cycle:
- the pad multiplexing against the hold state and direction register, in both the held and released states;
- that the sleep strobe always leaves the machine held, that a held state is left only through a release write, and that a release write takes effect;
- that soft reset and sleep entry leave the direction register alone and return both polarity bits to 1;
- that the reserved read bits stay zero.

Only the bench scenarios can show the rest: that the reset values are right, that a read is timed one cycle after its request, that a held direction write shows on the pins only after its edge, that the strobe wins over a release write in the same cycle, and that an unmapped write leaves the registers unchanged.

// File: rtl/psh_pkg.sv
`timescale 1ns/1ps
package psh_pkg;

    typedef enum logic [0:0] {
        ST_RELEASED = 1'b0,
        ST_HELD     = 1'b1
    } hold_state_e;

    localparam int ADDR_DIR  = 0;
    localparam int ADDR_CTRL = 1;

    localparam int CTRL_REL_BIT   = 0;
    localparam int CTRL_TXPOL_BIT = 1;
    localparam int CTRL_RXPOL_BIT = 2;
    localparam int CTRL_W         = 3;

endpackage

// File: rtl/psh_hold_fsm.sv
`timescale 1ns/1ps
module psh_hold_fsm
    import psh_pkg::*;
(
    input  logic clk,
    input  logic hw_rst_n,
    input  logic sleep_req,
    input  logic rel_set,
    output logic held
);

    hold_state_e state_q;
    hold_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            state_q <= ST_RELEASED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: SLEEP_ENTRY, SLEEP_AGAIN, RELEASE, STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RELEASED: begin
                if (sleep_req) begin
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (sleep_req) begin
                    state_d = ST_HELD;
                end else if (rel_set) begin
                    state_d = ST_RELEASED;
                end
            end
            default: state_d = ST_RELEASED;
        endcase
    end

    // outputs
    always_comb begin
        held = 1'b0;
        unique case (state_q)
            ST_RELEASED: held = 1'b0;
            ST_HELD:     held = 1'b1;
            default:     held = 1'b0;
        endcase
    end

    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sleep_req |=> held);  // R6

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (held && !rel_set) |=> held);  // R7

    AST_RELEASE_TAKES: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (held && rel_set && !sleep_req) |=> !held);  // R7

endmodule

// File: rtl/psh_regs.sv
`timescale 1ns/1ps
module psh_regs
    import psh_pkg::*;
#(
    parameter int NUM_PINS = 22,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                hw_rst_n,
    input  logic                soft_rst,
    input  logic                sleep_req,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                held,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic                rel_set,
    output logic                tx_pol,
    output logic                rx_pol
);

    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(ADDR_DIR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

    logic hit_dir;
    logic hit_ctrl;
    logic wr_dir;
    logic wr_ctrl;
    logic periph_rst;

    assign hit_dir    = (bus_addr == A_DIR);
    assign hit_ctrl   = (bus_addr == A_CTRL);
    assign wr_dir     = bus_we && hit_dir;
    assign wr_ctrl    = bus_we && hit_ctrl;
    assign rel_set    = wr_ctrl && bus_wdata[CTRL_REL_BIT];
    assign periph_rst = soft_rst || sleep_req;

    logic unused_wdata_bits;
    generate
        if (NUM_PINS < DATA_W) begin : g_unused
            assign unused_wdata_bits = ^bus_wdata[DATA_W-1:NUM_PINS];
        end else begin : g_nounused
            assign unused_wdata_bits = 1'b0;
        end
    endgenerate

    // direction register: only the hardware reset initialises it
    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            dir_q <= '1;
        end else if (wr_dir) begin
            dir_q <= bus_wdata[NUM_PINS-1:0];
        end
    end

    // serial-2 polarity bits: any peripheral reset restores 1
    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            tx_pol <= 1'b1;
            rx_pol <= 1'b1;
        end else if (periph_rst) begin
            tx_pol <= 1'b1;
            rx_pol <= 1'b1;
        end else if (wr_ctrl) begin
            tx_pol <= bus_wdata[CTRL_TXPOL_BIT];
            rx_pol <= bus_wdata[CTRL_RXPOL_BIT];
        end
    end

    // registered read path
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (hit_dir) begin
            rd_mux = DATA_W'(dir_q);
        end else if (hit_ctrl) begin
            rd_mux = DATA_W'({rx_pol, tx_pol, ~held});
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_mux;
        end else begin
            bus_rdata <= '0;
        end
    end

    AST_DIR_SURVIVES: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (periph_rst && !wr_dir) |=> $stable(dir_q));  // R8

    AST_POL_DEFAULT: assert property (@(posedge clk) disable iff (!hw_rst_n)
        periph_rst |=> (tx_pol && rx_pol));  // R9

    generate
        if (NUM_PINS < DATA_W) begin : g_rsvd
            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!hw_rst_n)
                bus_rdata[DATA_W-1:NUM_PINS] == '0);  // R2
        end
    endgenerate

endmodule

// File: rtl/psh_pin_mux.sv
`timescale 1ns/1ps
module psh_pin_mux #(
    parameter int NUM_PINS = 22
) (
    input  logic                held,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] periph_out,
    input  logic [NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            always_comb begin
                if (held) begin
                    pin_out[i] = 1'b0;
                    pin_oe[i]  = ~dir_q[i];
                end else begin
                    pin_out[i] = periph_out[i];
                    pin_oe[i]  = periph_oe[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pin_sleep_hold.sv
`timescale 1ns/1ps
module pin_sleep_hold
    import psh_pkg::*;
#(
    parameter int NUM_PINS = 22,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                hw_rst_n,
    input  logic                soft_rst,
    input  logic                sleep_req,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] periph_out,
    input  logic [NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                ser2_tx_pol,
    output logic                ser2_rx_pol
);

    logic                held;
    logic                rel_set;
    logic [NUM_PINS-1:0] dir_q;

    psh_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .hw_rst_n  (hw_rst_n),
        .soft_rst  (soft_rst),
        .sleep_req (sleep_req),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .held      (held),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .rel_set   (rel_set),
        .tx_pol    (ser2_tx_pol),
        .rx_pol    (ser2_rx_pol)
    );

    psh_hold_fsm u_fsm (
        .clk       (clk),
        .hw_rst_n  (hw_rst_n),
        .sleep_req (sleep_req),
        .rel_set   (rel_set),
        .held      (held)
    );

    psh_pin_mux #(
        .NUM_PINS (NUM_PINS)
    ) u_mux (
        .held       (held),
        .dir_q      (dir_q),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    AST_HELD_PADS: assert property (@(posedge clk) disable iff (!hw_rst_n)
        held |-> ((pin_out == '0) && (pin_oe == ~dir_q)));  // R5

    AST_RELEASED_PADS: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !held |-> ((pin_out == periph_out) && (pin_oe == periph_oe)));  // R4

endmodule

// File: tb/pin_sleep_hold_tb.sv
`timescale 1ns/1ps
module pin_sleep_hold_tb;

    localparam int NP = 22;
    localparam int DW = 32;
    localparam int AW = 2;
    localparam real CLK_NS = 8.0;
    localparam int VW = 1 + 5 * NP;
    localparam int NVEC = 6;

    // {held_mode, dir, periph_out, periph_oe, exp_pin_out, exp_pin_oe}
    localparam logic [VW-1:0] VEC [0:NVEC-1] = '{
        {1'b1, 22'h3FFFFF, 22'h3FFFFF, 22'h3FFFFF, 22'h000000, 22'h000000},
        {1'b1, 22'h000000, 22'h155555, 22'h3FFFFF, 22'h000000, 22'h3FFFFF},
        {1'b1, 22'h0F0F0F, 22'h3FFFFF, 22'h000000, 22'h000000, 22'h30F0F0},
        {1'b0, 22'h0F0F0F, 22'h155555, 22'h2AAAAA, 22'h155555, 22'h2AAAAA},
        {1'b0, 22'h000000, 22'h3FFFFF, 22'h000001, 22'h3FFFFF, 22'h000001},
        {1'b1, 22'h2AAAAA, 22'h000000, 22'h000000, 22'h000000, 22'h155555}
    };

    logic          clk = 1'b0;
    logic          hw_rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          sleep_req = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] periph_out = '0;
    logic [NP-1:0] periph_oe = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          ser2_tx_pol;
    logic          ser2_rx_pol;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    pin_sleep_hold #(.NUM_PINS(NP), .DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk (clk), .hw_rst_n (hw_rst_n), .soft_rst (soft_rst),
        .sleep_req (sleep_req), .bus_we (bus_we), .bus_re (bus_re),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .periph_out (periph_out), .periph_oe (periph_oe),
        .pin_out (pin_out), .pin_oe (pin_oe),
        .ser2_tx_pol (ser2_tx_pol), .ser2_rx_pol (ser2_rx_pol)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [DW-1:0] data);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = AW'(addr);
        @(negedge clk);
        bus_re = 1'b0;
        data = bus_rdata;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000.0);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        logic [VW-1:0] v;
        periph_out = 22'h12AB34; periph_oe = 22'h3C0F0F;
        repeat (3) @(negedge clk);
        hw_rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, r); check("R1 dir reset", r, 32'h003FFFFF);
        rd(1, r); check("R1 ctrl reset", r, 32'h7);
        check("R1 polarity", {30'd0, ser2_rx_pol, ser2_tx_pol}, 32'h3);
        check("R1 pins follow", {10'd0, pin_out}, {10'd0, periph_out});

        // R2 write all bits, reserved masked
        wr(0, 32'hFFFFFFFF); rd(0, r); check("R2 reserved zero", r, 32'h003FFFFF);
        wr(0, 32'h12345678); rd(0, r); check("R2 write", r, 32'h00345678);

        // R3 read timing
        @(negedge clk); bus_re = 1'b1; bus_addr = AW'(0);
        #1 check("R3 idle rdata zero", bus_rdata, 32'h0);
        @(negedge clk); bus_re = 1'b0;
        check("R3 data next cycle", bus_rdata, 32'h00345678);
        @(negedge clk);
        check("R3 rdata clears", bus_rdata, 32'h0);

        // R4 / R5 vector walk
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            wr(0, DW'(v[5*NP-1:4*NP]));
            periph_out = v[4*NP-1:3*NP];
            periph_oe  = v[3*NP-1:2*NP];
            if (v[VW-1]) pulse_sleep();
            else wr(1, 32'h7);
            @(negedge clk);
            check(v[VW-1] ? "R5 held pin_out" : "R4 released pin_out",
                  DW'(pin_out), DW'(v[2*NP-1:NP]));
            check(v[VW-1] ? "R5 held pin_oe" : "R4 released pin_oe",
                  DW'(pin_oe), DW'(v[NP-1:0]));
        end

        // currently held with dir 2AAAAA
        // R7 writing 0 to release bit has no effect
        wr(1, 32'h6); rd(1, r); check("R7 write 0 ignored", r, 32'h6);
        check("R7 still held", DW'(pin_oe), 32'h00155555);
        wr(1, 32'h7); rd(1, r); check("R7 write 1 releases", r, 32'h7);
        check("R7 pins released", DW'(pin_oe), DW'(periph_oe));

        // R6 sleep wins over same-cycle release
        @(negedge clk);
        sleep_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(1); bus_wdata = 32'h7;
        @(negedge clk);
        sleep_req = 1'b0; bus_we = 1'b0;
        rd(1, r); check("R6 sleep wins", r, 32'h6);
        check("R6 pins held", DW'(pin_oe), 32'h00155555);

        // R10 held direction write shows only after edge
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(0); bus_wdata = 32'h000000FF;
        #1 check("R10 before edge", DW'(pin_oe), 32'h00155555);
        @(negedge clk); bus_we = 1'b0;
        check("R10 after edge", DW'(pin_oe), 32'h003FFF00);

        // R8 soft reset and sleep keep dir
        pulse_soft(); rd(0, r); check("R8 soft keeps dir", r, 32'h000000FF);
        pulse_sleep(); rd(0, r); check("R8 sleep keeps dir", r, 32'h000000FF);

        // R9 polarity write and restore
        wr(1, 32'h1);
        check("R9 polarity written", {30'd0, ser2_rx_pol, ser2_tx_pol}, 32'h0);
        pulse_soft();
        check("R9 soft restores", {30'd0, ser2_rx_pol, ser2_tx_pol}, 32'h3);
        wr(1, 32'h1);
        pulse_sleep();
        check("R9 sleep restores", {30'd0, ser2_rx_pol, ser2_tx_pol}, 32'h3);
        @(negedge clk);
        soft_rst = 1'b1; bus_we = 1'b1; bus_addr = AW'(1); bus_wdata = 32'h1;
        @(negedge clk); soft_rst = 1'b0; bus_we = 1'b0;
        check("R9 reset beats write", {30'd0, ser2_rx_pol, ser2_tx_pol}, 32'h3);
        rd(1, r); check("R9 release via same write", r, 32'h7);

        // R11 unmapped address
        wr(2, 32'hFFFFFFFF); rd(2, r); check("R11 unmapped reads zero", r, 32'h0);
        rd(0, r); check("R11 dir untouched", r, 32'h000000FF);
        wr(3, 32'h0); rd(1, r); check("R11 ctrl untouched", r, 32'h7);

        // R1 hardware reset mid-run
        wr(0, 32'h0); pulse_sleep();
        @(negedge clk); hw_rst_n = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1;
        rd(0, r); check("R1 hw reset dir", r, 32'h003FFFFF);
        rd(1, r); check("R1 hw reset ctrl", r, 32'h7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule